// File: doc/BRIEF.md
# CCD Readout Timing Sequencer

This block generates the digital timing for reading one frame out of a progressive-scan interline CCD. A frame-start request arms a fixed sequence of lines. Each line begins with a vertical charge transfer made of two vertical phase windows. A settling hold follows, then a train of horizontal shift periods carrying the reset-gate pulse and a pixel sample strobe, then a guard gap before the next vertical transfer. Light-shielded gray lines can optionally be discarded through the fast dump gate instead of being shifted out. After the last line a single shutter strobe marks the start of the next integration.

Every pixel strobe carries class flags for the capture logic: one for image pixels and one for dark reference columns. Level flags mark gray lines and image lines. The block supports a one-channel mode and a two-channel mode. In two-channel mode each line is half as long, and the right half of the horizontal register is driven with swapped phases so that it shifts toward its own output. Row bands and column bands are parameters in lines and pixels. All durations are parameters in nanoseconds, which are rounded up to whole cycles of the system clock.

Top module: `ccd_readout_seq`

## Requirements
- R1: After reset, and whenever idle, every output is 0 and `busy` is 0.
- R2: A `frame_start` seen while idle begins a frame of GRAY_TOP + PHOTO + GRAY_BOT lines, with `busy` high from the next cycle. A `frame_start` that arrives while busy has no effect on the sequence.
- R3: A line that is read out runs VX cycles of vertical transfer, with `v_ph1` on the first VX/2 cycles and `v_ph2` on the rest. It then runs HOLD idle cycles, NPIX pixel periods and GAP idle cycles. At least GAP cycles separate the last horizontal clock from the next vertical phase.
- R4: A pixel period is PIX cycles long. `hl_ph1` is high on its first PIX/2 cycles and `hl_ph2` on the remaining ones. `reset_gate` is high on its first cycle and `pix_stb` on its last cycle.
- R5: In one-channel mode NPIX = EMPTY + DARK + PHOTO + DARK. The column order is empty, dark, buffer, active, buffer, dark, with BUF buffer columns at each edge of the photosensitive run.
- R6: In two-channel mode NPIX = EMPTY + DARK + PHOTO/2, with columns empty, dark, BUF buffer and then active. `hr_ph1`/`hr_ph2` equal `hl_ph2`/`hl_ph1`; in one-channel mode they equal `hl_ph1`/`hl_ph2`.
- R7: `pix_active` is high only with `pix_stb`, on an image line, in an active column. A frame gives IMG_ROWS × (PHOTO − 2·BUF) such strobes in one-channel mode and IMG_ROWS × (PHOTO/2 − BUF) in two-channel mode.
- R8: `pix_dark` is high with `pix_stb` in dark columns, on every line that is read out.
- R9: `line_gray` is high for the whole duration of the first GRAY_TOP lines and of the last GRAY_BOT lines. `line_image` is high for the photoactive lines that are not among the first or last BUF_ROWS photoactive lines.
- R10: When `dump_gray` was set at frame start, each gray line instead runs FD cycles of `dump_gate`, then the vertical transfer with `dump_gate` still high, then FD more cycles of `dump_gate`, then GAP cycles. No horizontal clock, reset gate or strobe occurs on such a line.
- R11: After the last line's gap, `shutter_stb` is high for SHUT cycles and the block then returns to idle.
- R12: `dual_mode` and `dump_gray` are sampled only when a frame starts. Changes to them during a frame have no effect.
- R13: Each duration in cycles is ceil(ns × CLK_MHZ / 1000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Request to read out one frame |
| dual_mode | input | 1 | 1 selects two-channel readout |
| dump_gray | input | 1 | 1 discards gray lines through the dump gate |
| v_ph1 | output | 1 | Vertical transfer phase 1 window |
| v_ph2 | output | 1 | Vertical transfer phase 2 window |
| hl_ph1 | output | 1 | Left horizontal phase 1 |
| hl_ph2 | output | 1 | Left horizontal phase 2 |
| hr_ph1 | output | 1 | Right horizontal phase 1 |
| hr_ph2 | output | 1 | Right horizontal phase 2 |
| reset_gate | output | 1 | Output node reset enable |
| dump_gate | output | 1 | Fast line dump gate |
| shutter_stb | output | 1 | Electronic shutter strobe |
| pix_stb | output | 1 | Pixel sample strobe |
| pix_active | output | 1 | Strobe is an image pixel |
| pix_dark | output | 1 | Strobe is a dark reference pixel |
| line_gray | output | 1 | Current line is a gray row |
| line_image | output | 1 | Current line is an image row |
| busy | output | 1 | Frame in progress |

## Verification
Four whole frames are read out, one for each combination of channel mode and gray dumping. This tells the one-channel column map apart from the two-channel map, and it tells dumped gray lines apart from gray lines that are shifted out. The frame with both options off also carries a mid-frame start request together with flipped mode inputs, so that a restart or a late re-sampling shows up as a divergence on the next cycle. The hold duration is given in a value that does not divide evenly into cycles, which exposes truncation in place of round-up. Every output is compared on every cycle with a model built from the band and duration constants. Per-frame totals of strobes, image pixels, dark pixels and vertical phase cycles are then checked on top of that.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FDLEAD,
        ST_VX,
        ST_FDTRAIL,
        ST_HOLD,
        ST_SHIFT,
        ST_GAP,
        ST_SHUT
    } seq_state_e;

    typedef enum logic [1:0] {
        COL_EMPTY,
        COL_DARK,
        COL_BUF,
        COL_ACT
    } col_class_e;

    typedef enum logic [1:0] {
        ROW_GRAY,
        ROW_BUF,
        ROW_IMG
    } row_class_e;

    // Rounds a duration in ns up to whole clock cycles.
    function automatic int ns2cyc(input int ns, input int mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

endpackage

// File: rtl/ccdseq_rowclass.sv
module ccdseq_rowclass
    import ccdseq_pkg::*;
#(
    parameter int GRAY_TOP = 40,
    parameter int PHOTO    = 3280,
    parameter int BUF_ROWS = 16,
    parameter int LW       = 12
) (
    input  logic [LW-1:0] line,
    output row_class_e    cls
);
    localparam logic [LW-1:0] PH_LO  = LW'(GRAY_TOP);
    localparam logic [LW-1:0] PH_HI  = LW'(GRAY_TOP + PHOTO);
    localparam logic [LW-1:0] IMG_LO = LW'(GRAY_TOP + BUF_ROWS);
    localparam logic [LW-1:0] IMG_HI = LW'(GRAY_TOP + PHOTO - BUF_ROWS);

    always_comb begin
        if (line < PH_LO || line >= PH_HI)
            cls = ROW_GRAY;
        else if (line >= IMG_LO && line < IMG_HI)
            cls = ROW_IMG;
        else
            cls = ROW_BUF;
    end
endmodule

// File: rtl/ccdseq_colclass.sv
module ccdseq_colclass
    import ccdseq_pkg::*;
#(
    parameter int EMPTY = 12,
    parameter int DARK  = 28,
    parameter int PHOTO = 4904,
    parameter int BUF   = 16,
    parameter int PW    = 13
) (
    input  logic [PW-1:0] idx,
    input  logic          dual,
    output col_class_e    cls
);
    localparam logic [PW-1:0] DK_LO  = PW'(EMPTY);
    localparam logic [PW-1:0] BF_LO  = PW'(EMPTY + DARK);
    localparam logic [PW-1:0] ACT_LO = PW'(EMPTY + DARK + BUF);
    localparam logic [PW-1:0] ACT_HI = PW'(EMPTY + DARK + PHOTO - BUF);
    localparam logic [PW-1:0] DK2_LO = PW'(EMPTY + DARK + PHOTO);

    always_comb begin
        if (idx < DK_LO)
            cls = COL_EMPTY;
        else if (idx < BF_LO)
            cls = COL_DARK;
        else if (idx < ACT_LO)
            cls = COL_BUF;
        else if (dual)
            cls = COL_ACT;           // half register: inner edge has no buffer
        else if (idx < ACT_HI)
            cls = COL_ACT;
        else if (idx < DK2_LO)
            cls = COL_BUF;
        else
            cls = COL_DARK;
    end
endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq
    import ccdseq_pkg::*;
#(
    parameter int CLK_MHZ       = 250,
    parameter int ROWS_GRAY_TOP = 40,
    parameter int ROWS_PHOTO    = 3280,
    parameter int ROWS_BUF      = 16,
    parameter int ROWS_GRAY_BOT = 4,
    parameter int COLS_EMPTY    = 12,
    parameter int COLS_DARK     = 28,
    parameter int COLS_PHOTO    = 4904,
    parameter int COLS_BUF      = 16,
    parameter int VX_NS         = 4000,
    parameter int HOLD_NS       = 4000,
    parameter int GAP_NS        = 50,
    parameter int FD_NS         = 500,
    parameter int PIX_NS        = 34,
    parameter int SHUT_NS       = 4000
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_start,
    input  logic dual_mode,
    input  logic dump_gray,
    output logic v_ph1,
    output logic v_ph2,
    output logic hl_ph1,
    output logic hl_ph2,
    output logic hr_ph1,
    output logic hr_ph2,
    output logic reset_gate,
    output logic dump_gate,
    output logic shutter_stb,
    output logic pix_stb,
    output logic pix_active,
    output logic pix_dark,
    output logic line_gray,
    output logic line_image,
    output logic busy
);
    // Derived durations (R13)
    localparam int VXC   = ns2cyc(VX_NS, CLK_MHZ);
    localparam int HOLDC = ns2cyc(HOLD_NS, CLK_MHZ);
    localparam int GAPC  = ns2cyc(GAP_NS, CLK_MHZ);
    localparam int FDC   = ns2cyc(FD_NS, CLK_MHZ);
    localparam int PIXC  = ns2cyc(PIX_NS, CLK_MHZ);
    localparam int SHUTC = ns2cyc(SHUT_NS, CLK_MHZ);
    localparam int M1    = (VXC > HOLDC) ? VXC : HOLDC;
    localparam int M2    = (GAPC > FDC) ? GAPC : FDC;
    localparam int M3    = (PIXC > SHUTC) ? PIXC : SHUTC;
    localparam int M12   = (M1 > M2) ? M1 : M2;
    localparam int TMAX  = (M12 > M3) ? M12 : M3;
    localparam int TW    = $clog2(TMAX + 1);

    // Derived geometry
    localparam int LINES  = ROWS_GRAY_TOP + ROWS_PHOTO + ROWS_GRAY_BOT;
    localparam int NPIX_S = COLS_EMPTY + 2 * COLS_DARK + COLS_PHOTO;
    localparam int NPIX_D = COLS_EMPTY + COLS_DARK + COLS_PHOTO / 2;
    localparam int LW     = $clog2(LINES + 1);
    localparam int PW     = $clog2(NPIX_S + 1);

    localparam logic [TW-1:0] VX_LAST   = TW'(VXC - 1);
    localparam logic [TW-1:0] HOLD_LAST = TW'(HOLDC - 1);
    localparam logic [TW-1:0] GAP_LAST  = TW'(GAPC - 1);
    localparam logic [TW-1:0] FD_LAST   = TW'(FDC - 1);
    localparam logic [TW-1:0] PIX_LAST  = TW'(PIXC - 1);
    localparam logic [TW-1:0] SHUT_LAST = TW'(SHUTC - 1);
    localparam logic [TW-1:0] VX_HALF   = TW'(VXC / 2);
    localparam logic [TW-1:0] PIX_HALF  = TW'(PIXC / 2);
    localparam logic [PW-1:0] LAST_S    = PW'(NPIX_S - 1);
    localparam logic [PW-1:0] LAST_D    = PW'(NPIX_D - 1);
    localparam logic [LW-1:0] LAST_LINE = LW'(LINES - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [TW-1:0] tmr;
        logic [PW-1:0] pix;
        logic [LW-1:0] line;
        logic          dual;
        logic          dump;
    } seq_s;

    seq_s d, q;

    logic [LW-1:0] nxt_line;
    row_class_e    cur_row, nxt_row;
    col_class_e    cur_col;
    logic          dump_eff, nxt_dumped, cur_dumped, go_line, tmr_done;
    logic [TW-1:0] cur_last;
    logic          h1, h2;

    assign nxt_line = (q.st == ST_IDLE) ? '0 : q.line + 1'b1;

    ccdseq_rowclass #(
        .GRAY_TOP(ROWS_GRAY_TOP), .PHOTO(ROWS_PHOTO), .BUF_ROWS(ROWS_BUF), .LW(LW)
    ) u_row_cur (.line(q.line), .cls(cur_row));

    ccdseq_rowclass #(
        .GRAY_TOP(ROWS_GRAY_TOP), .PHOTO(ROWS_PHOTO), .BUF_ROWS(ROWS_BUF), .LW(LW)
    ) u_row_nxt (.line(nxt_line), .cls(nxt_row));

    ccdseq_colclass #(
        .EMPTY(COLS_EMPTY), .DARK(COLS_DARK), .PHOTO(COLS_PHOTO), .BUF(COLS_BUF), .PW(PW)
    ) u_col (.idx(q.pix), .dual(q.dual), .cls(cur_col));

    assign dump_eff   = (q.st == ST_IDLE) ? dump_gray : q.dump;
    assign nxt_dumped = dump_eff && (nxt_row == ROW_GRAY);
    assign cur_dumped = q.dump && (cur_row == ROW_GRAY);

    always_comb begin
        unique case (q.st)
            ST_FDLEAD, ST_FDTRAIL: cur_last = FD_LAST;
            ST_VX:                 cur_last = VX_LAST;
            ST_HOLD:               cur_last = HOLD_LAST;
            ST_SHIFT:              cur_last = PIX_LAST;
            ST_GAP:                cur_last = GAP_LAST;
            ST_SHUT:               cur_last = SHUT_LAST;
            default:               cur_last = '0;
        endcase
    end
    assign tmr_done = (q.tmr == cur_last);

    always_comb begin
        d       = q;
        go_line = 1'b0;
        if (q.st != ST_IDLE)
            d.tmr = tmr_done ? '0 : q.tmr + 1'b1;
        unique case (q.st)
            ST_IDLE: if (frame_start) begin
                d.dual  = dual_mode;
                d.dump  = dump_gray;
                go_line = 1'b1;
            end
            ST_FDLEAD:  if (tmr_done) d.st = ST_VX;
            ST_VX:      if (tmr_done) d.st = cur_dumped ? ST_FDTRAIL : ST_HOLD;
            ST_FDTRAIL: if (tmr_done) d.st = ST_GAP;
            ST_HOLD: if (tmr_done) begin
                d.st  = ST_SHIFT;
                d.pix = '0;
            end
            ST_SHIFT: if (tmr_done) begin
                if (q.pix == (q.dual ? LAST_D : LAST_S))
                    d.st = ST_GAP;
                else
                    d.pix = q.pix + 1'b1;
            end
            ST_GAP: if (tmr_done) begin
                if (q.line == LAST_LINE)
                    d.st = ST_SHUT;
                else
                    go_line = 1'b1;
            end
            ST_SHUT:  if (tmr_done) d.st = ST_IDLE;
            default:  d.st = ST_IDLE;
        endcase
        if (go_line) begin
            d.line = nxt_line;
            d.tmr  = '0;
            d.pix  = '0;
            d.st   = nxt_dumped ? ST_FDLEAD : ST_VX;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st   <= ST_IDLE;
            q.tmr  <= '0;
            q.pix  <= '0;
            q.line <= '0;
            q.dual <= 1'b0;
            q.dump <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // Output decode
    assign h1 = (q.st == ST_SHIFT) && (q.tmr < PIX_HALF);
    assign h2 = (q.st == ST_SHIFT) && (q.tmr >= PIX_HALF);

    assign busy        = (q.st != ST_IDLE);
    assign v_ph1       = (q.st == ST_VX) && (q.tmr < VX_HALF);
    assign v_ph2       = (q.st == ST_VX) && (q.tmr >= VX_HALF);
    assign hl_ph1      = h1;
    assign hl_ph2      = h2;
    assign hr_ph1      = q.dual ? h2 : h1;
    assign hr_ph2      = q.dual ? h1 : h2;
    assign reset_gate  = (q.st == ST_SHIFT) && (q.tmr == '0);
    assign pix_stb     = (q.st == ST_SHIFT) && (q.tmr == PIX_LAST);
    assign dump_gate   = (q.st == ST_FDLEAD) || (q.st == ST_FDTRAIL) ||
                         ((q.st == ST_VX) && cur_dumped);
    assign shutter_stb = (q.st == ST_SHUT);
    assign line_gray   = busy && !shutter_stb && (cur_row == ROW_GRAY);
    assign line_image  = busy && !shutter_stb && (cur_row == ROW_IMG);
    assign pix_active  = pix_stb && (cur_row == ROW_IMG) && (cur_col == COL_ACT);
    assign pix_dark    = pix_stb && (cur_col == COL_DARK);

    // Assertions
    logic [TW:0] since_h_q, since_v_q;
    localparam logic [TW:0] SAT      = '1;
    localparam logic [TW:0] GAP_MIN  = (TW+1)'(GAPC);
    localparam logic [TW:0] HOLD_MIN = (TW+1)'(HOLDC);

    always_ff @(posedge clk) begin
        if (rst) begin
            since_h_q <= SAT;
            since_v_q <= SAT;
        end else begin
            since_h_q <= (hl_ph1 || hl_ph2) ? '0 : ((since_h_q == SAT) ? SAT : since_h_q + 1'b1);
            since_v_q <= (v_ph1 || v_ph2)   ? '0 : ((since_v_q == SAT) ? SAT : since_v_q + 1'b1);
        end
    end

    assert_gap_before_vx_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(v_ph1) |-> since_h_q >= GAP_MIN);
    assert_hold_after_vx_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(hl_ph1) |-> since_v_q >= HOLD_MIN);
    assert_vphase_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({v_ph1, v_ph2, hl_ph1, hl_ph2}));
    assert_no_hclk_in_dump_R10: assert property (@(posedge clk) disable iff (rst)
        dump_gate |-> !(hl_ph1 || hl_ph2 || reset_gate || pix_stb));
    assert_active_qualified_R7: assert property (@(posedge clk) disable iff (rst)
        pix_active |-> (pix_stb && line_image));
    assert_start_only_from_req_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(frame_start));
    assert_shutter_before_idle_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(shutter_stb));
    assert_right_phase_swap_R6: assert property (@(posedge clk) disable iff (rst)
        (hr_ph1 || hr_ph2) |-> ((hr_ph1 == hl_ph1) != q.dual));
endmodule

// File: tb/ccd_readout_seq_test.sv
`timescale 1ns/1ps
module ccd_readout_seq_test;
    // Scaled geometry
    localparam int GT = 2, PR = 5, BR = 1, GB = 1;
    localparam int E = 2, DK = 2, P = 8, B = 1;
    localparam int LINES = GT + PR + GB;
    // Durations in cycles at 250 MHz, rounded up by hand (R13)
    localparam int VXC = 6, HOLDC = 3, GAPC = 2, FDC = 2, PIXC = 2, SHUTC = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic frame_start = 1'b0, dual_mode = 1'b0, dump_gray = 1'b0;
    logic v_ph1, v_ph2, hl_ph1, hl_ph2, hr_ph1, hr_ph2, reset_gate, dump_gate;
    logic shutter_stb, pix_stb, pix_active, pix_dark, line_gray, line_image, busy;

    always #2 clk = ~clk;

    ccd_readout_seq #(
        .CLK_MHZ(250), .ROWS_GRAY_TOP(GT), .ROWS_PHOTO(PR), .ROWS_BUF(BR), .ROWS_GRAY_BOT(GB),
        .COLS_EMPTY(E), .COLS_DARK(DK), .COLS_PHOTO(P), .COLS_BUF(B),
        .VX_NS(24), .HOLD_NS(10), .GAP_NS(8), .FD_NS(8), .PIX_NS(8), .SHUT_NS(16)
    ) uut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .dual_mode(dual_mode),
        .dump_gray(dump_gray), .v_ph1(v_ph1), .v_ph2(v_ph2), .hl_ph1(hl_ph1),
        .hl_ph2(hl_ph2), .hr_ph1(hr_ph1), .hr_ph2(hr_ph2), .reset_gate(reset_gate),
        .dump_gate(dump_gate), .shutter_stb(shutter_stb), .pix_stb(pix_stb),
        .pix_active(pix_active), .pix_dark(pix_dark), .line_gray(line_gray),
        .line_image(line_image), .busy(busy)
    );

    int vectors = 0, miscompares = 0, cyc = 0;
    int n_stb, n_act, n_dark, n_v;
    logic [14:0] exp_q[$];

    function automatic string tag_of(int b);
        case (b)
            14: return "R2";  13: return "R11"; 12: return "R9";  11: return "R9";
            10: return "R10"; 9:  return "R3";  8:  return "R3";  7:  return "R4";
            6:  return "R4";  5:  return "R6";  4:  return "R6";  3:  return "R4";
            2:  return "R4";  1:  return "R7";  default: return "R8";
        endcase
    endfunction

    function automatic logic [14:0] sample();
        return {busy, shutter_stb, line_gray, line_image, dump_gate, v_ph1, v_ph2,
                hl_ph1, hl_ph2, hr_ph1, hr_ph2, reset_gate, pix_stb, pix_active, pix_dark};
    endfunction

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    task automatic tick();
        logic [14:0] got, exp;
        @(negedge clk);
        cyc++;
        got = sample();
        exp = (exp_q.size() > 0) ? exp_q.pop_front() : 15'b0;
        vectors++;
        if (got !== exp) begin
            int b = 0;
            miscompares++;
            for (int k = 14; k >= 0; k--) if (got[k] !== exp[k]) begin b = k; break; end
            $display("FAIL %s cycle %0d: got %b expected %b", tag_of(b), cyc, got, exp);
        end
        n_stb  += int'(pix_stb);
        n_act  += int'(pix_active);
        n_dark += int'(pix_dark);
        n_v    += int'(v_ph1 | v_ph2);
    endtask

    task automatic check(string tag, int got, int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic push(logic g, logic im, logic fd, logic v1, logic v2, logic h1, logic h2,
                        logic dual, logic rg, logic stb, logic act, logic dk, logic sh);
        exp_q.push_back({1'b1, sh, g, im, fd, v1, v2, h1, h2,
                         dual ? h2 : h1, dual ? h1 : h2, rg, stb, act, dk});
    endtask

    // Behavioural frame model built from the requirements
    task automatic build_frame(logic dual, logic dump);
        int npix = dual ? (E + DK + P / 2) : (E + 2 * DK + P);
        for (int ln = 0; ln < LINES; ln++) begin
            logic g  = (ln < GT) || (ln >= GT + PR);
            logic im = (ln >= GT + BR) && (ln < GT + PR - BR);
            if (dump && g) begin                                     // R10
                for (int c = 0; c < FDC; c++) push(g, im, 1, 0, 0, 0, 0, dual, 0, 0, 0, 0, 0);
                for (int c = 0; c < VXC; c++)
                    push(g, im, 1, c < VXC / 2, c >= VXC / 2, 0, 0, dual, 0, 0, 0, 0, 0);
                for (int c = 0; c < FDC; c++) push(g, im, 1, 0, 0, 0, 0, dual, 0, 0, 0, 0, 0);
            end else begin                                           // R3
                for (int c = 0; c < VXC; c++)
                    push(g, im, 0, c < VXC / 2, c >= VXC / 2, 0, 0, dual, 0, 0, 0, 0, 0);
                for (int c = 0; c < HOLDC; c++) push(g, im, 0, 0, 0, 0, 0, dual, 0, 0, 0, 0, 0);
                for (int p = 0; p < npix; p++) begin                 // R5, R6
                    logic dark = (p >= E && p < E + DK) || (!dual && p >= E + DK + P);
                    logic actc = dual ? (p >= E + DK + B)
                                      : (p >= E + DK + B && p < E + DK + P - B);
                    for (int c = 0; c < PIXC; c++) begin             // R4
                        logic stb = (c == PIXC - 1);
                        push(g, im, 0, 0, 0, c < PIXC / 2, c >= PIXC / 2, dual, c == 0, stb,
                             stb && im && actc, stb && dark, 0);
                    end
                end
            end
            for (int c = 0; c < GAPC; c++) push(g, im, 0, 0, 0, 0, 0, dual, 0, 0, 0, 0, 0);
        end
        for (int c = 0; c < SHUTC; c++) push(0, 0, 0, 0, 0, 0, 0, dual, 0, 0, 0, 0, 1); // R11
    endtask

    task automatic run_frame(logic dual, logic dump, logic disturb);
        int read_lines = (dump ? PR : LINES);
        int img_rows   = PR - 2 * BR;
        int npix       = dual ? (E + DK + P / 2) : (E + 2 * DK + P);
        n_stb = 0; n_act = 0; n_dark = 0; n_v = 0;
        dual_mode = dual; dump_gray = dump; frame_start = 1'b1;
        build_frame(dual, dump);
        tick();
        frame_start = 1'b0;
        dual_mode = 1'b0; dump_gray = 1'b0;
        for (int k = 0; k < 40; k++) tick();
        if (disturb) begin
            // R2: start request mid-frame ignored; R12: mode inputs flipped mid-frame
            frame_start = 1'b1; dual_mode = ~dual; dump_gray = ~dump;
            tick();
            frame_start = 1'b0;
            for (int k = 0; k < 60; k++) tick();
            dual_mode = 1'b0; dump_gray = 1'b0;
        end
        while (exp_q.size() > 0) tick();
        for (int k = 0; k < 3; k++) tick();   // R1 idle after frame
        check("R5 strobes per frame", n_stb, read_lines * npix);
        check("R7 image pixels per frame", n_act, img_rows * (dual ? (P / 2 - B) : (P - 2 * B)));
        check("R8 dark pixels per frame", n_dark, read_lines * (dual ? DK : 2 * DK));
        check("R13 vertical phase cycles per frame", n_v, LINES * VXC);
    endtask

    initial begin
        #600000;
        miscompares++;
        $display("FAIL R2 watchdog: got busy, expected frame end");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset state", int'(sample()), 0);
        for (int k = 0; k < 4; k++) tick();
        run_frame(1'b0, 1'b0, 1'b1);
        run_frame(1'b0, 1'b1, 1'b0);
        run_frame(1'b1, 1'b1, 1'b0);
        run_frame(1'b1, 1'b0, 1'b0);
        summary();
        $finish;
    end
endmodule